// File: doc/BRIEF.md
# Column-Keyed Word Shuffler

This block reorders the chip-sized words of one cache line so that the word which lands in each DRAM chip depends on the column being accessed. A line holds `2**STAGES` words of `WORD_W` bits. With no reordering, word i goes to chip i. The reordering is a chain of `STAGES` swap stages, and the low column-address bits switch them on and off one by one. When an array of fixed-size records is walked with a power-of-two stride, the same field from successive columns then lands in different chips. A controller can therefore collect one useful word from every chip in a single access, where otherwise all of them would collide in one chip.

The same block serves both directions. Before a write it shuffles the line. After a read it restores the line, using the same column ID. Every stage swaps whole groups and so undoes itself, and the stages commute with each other. In read mode the stages are applied in reverse order, and the result is identical to the write mode. The data path is combinational, with an optional output register chosen by a parameter. A valid bit travels alongside the data.

Top module: `col_shuffle`

## Requirements
- R1: When the low `STAGES` bits of the column ID are all zero, every output word equals the input word at the same index.
- R2: Stage k (k from 1) is active only when column bit k-1 is 1. When active it exchanges adjacent groups of 2^(k-1) words. Taken together, output word j equals input word (j XOR c), where c is the low `STAGES` bits of the column ID.
- R3: Column ID bits at positions `STAGES` and above have no effect on the output.
- R4: The direction select (`in_read`: 0 = shuffle for write, 1 = restore after read) does not change the output for a given line and column ID.
- R5: Restoring a shuffled line with the same column ID returns the original line, for every column ID.
- R6: With `REG_OUT`=1, `out_valid` equals `in_valid` of the previous clock, and `out_data` carries the permuted line from that same clock. With `REG_OUT`=0 both outputs follow the inputs in the same cycle.
- R7: With `REG_OUT`=1, `out_data` keeps its value over any clock in which `in_valid` is 0.
- R8: While `rst_n` is low, `out_valid` is 0.
- R9: For `STAGES`=3, take columns 0..7 and, in column c, the word at logical index (s*c mod 8) for stride s of 2, 4 or 8. These eight words end up in eight different chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input line is valid |
| in_read | input | 1 | 0 = shuffle before write, 1 = restore after read |
| in_col | input | COL_W | Column ID of the access |
| in_data | input | WORD_W*2**STAGES | Cache line, word i in bits [i*WORD_W +: WORD_W] |
| out_valid | output | 1 | Output line is valid |
| out_data | output | WORD_W*2**STAGES | Permuted line, word j in bits [j*WORD_W +: WORD_W] |

## Verification
With the default `REG_OUT`=1, each result appears one clock after its stimulus. The bench drives the inputs on a falling edge and reads the outputs on the next falling edge. That is half a period after the rising edge that registers them. The hold check drops `in_valid`, changes the data and column, and reads again one falling edge later, when a wrongly loaded register would already show the new value. For the round trip, the output captured from the first pass is fed back as the next stimulus, and the result is read one clock after that.

// File: rtl/col_shuffle.sv
module col_shuffle #(
  parameter int WORD_W  = 64,
  parameter int STAGES  = 3,
  parameter int COL_W   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic                                in_read,
  input  logic [COL_W-1:0]                    in_col,
  input  logic [WORD_W*(2**STAGES)-1:0]       in_data,
  output logic                                out_valid,
  output logic [WORD_W*(2**STAGES)-1:0]       out_data
);
  localparam int WORDS  = 2 ** STAGES;
  localparam int LINE_W = WORD_W * WORDS;

  logic [LINE_W-1:0] fwd [STAGES+1];
  logic [LINE_W-1:0] rev [STAGES+1];
  logic [LINE_W-1:0] mixed;

  assign fwd[0]      = in_data;
  assign rev[STAGES] = in_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int PEER = w ^ (1 << s);
      assign fwd[s+1][w*WORD_W +: WORD_W] = in_col[s] ? fwd[s][PEER*WORD_W +: WORD_W]
                                                      : fwd[s][w*WORD_W +: WORD_W];
      assign rev[s][w*WORD_W +: WORD_W]   = in_col[s] ? rev[s+1][PEER*WORD_W +: WORD_W]
                                                      : rev[s+1][w*WORD_W +: WORD_W];
    end
  end

  assign mixed = in_read ? rev[0] : fwd[STAGES];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_data  <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_data <= mixed;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid & rst_n;
    assign out_data  = mixed;
  end
endmodule

module col_shuffle_chk #(
  parameter int WORD_W  = 64,
  parameter int STAGES  = 3,
  parameter int COL_W   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [COL_W-1:0]              in_col,
  input logic [WORD_W*(2**STAGES)-1:0] in_data,
  input logic                          out_valid,
  input logic [WORD_W*(2**STAGES)-1:0] out_data
);
  localparam int WORDS = 2 ** STAGES;
  logic [STAGES-1:0] sel;
  logic [WORD_W-1:0] src0, srcl;
  assign sel  = in_col[STAGES-1:0];
  assign src0 = in_data[int'(sel)*WORD_W +: WORD_W];
  assign srcl = in_data[int'(sel ^ STAGES'(WORDS-1))*WORD_W +: WORD_W];

  always_comb if (!rst_n) AST_RESET_IDLE: assert (!out_valid || !REG_OUT); // R8

  if (REG_OUT) begin : g_seq
    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid)); // R6
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == '0) |=> out_data == $past(in_data)); // R1
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_data[WORD_W-1:0] == $past(src0)); // R2
    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_data[(WORDS-1)*WORD_W +: WORD_W] == $past(srcl)); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R7
  end else begin : g_cmb
    AST_VALID_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid); // R6
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_data[WORD_W-1:0] == src0); // R2
    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_data[(WORDS-1)*WORD_W +: WORD_W] == srcl); // R2
  end
endmodule

bind col_shuffle col_shuffle_chk #(
  .WORD_W(WORD_W), .STAGES(STAGES), .COL_W(COL_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_col_shuffle.sv
`timescale 1ns/1ps
module sim_col_shuffle;
  localparam int W = 64, S = 3, CW = 6, N = 8, LW = W * N;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_read = 1'b0;
  logic [CW-1:0] in_col = '0;
  logic [LW-1:0] in_data = '0;
  logic out_valid;
  logic [LW-1:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  col_shuffle #(.WORD_W(W), .STAGES(S), .COL_W(CW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_read(in_read),
    .in_col(in_col), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  function automatic logic [LW-1:0] make_line(int seed, int col, int dir);
    logic [LW-1:0] l;
    for (int i = 0; i < N; i++)
      l[i*W +: W] = {16'(16'hA5C3 ^ seed), 16'(col), 16'(dir), 16'(i)};
    return l;
  endfunction

  function automatic logic [LW-1:0] expect_line(logic [LW-1:0] d, int col);
    logic [LW-1:0] e;
    for (int j = 0; j < N; j++) e[j*W +: W] = d[(j ^ (col % N))*W +: W];
    return e;
  endfunction

  task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(int col, int dir, logic [LW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_col = CW'(col); in_read = dir[0]; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] d, e, first;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", LW'(out_valid), LW'(0));
    rst_n = 1'b1;

    // R1 R2 R3 R4 R6: exhaustive over column IDs and both directions
    for (int col = 0; col < (1 << CW); col++) begin
      for (int dir = 0; dir < 2; dir++) begin
        d = make_line(col * 7 + dir, col, dir);
        push(col, dir, d);
        check("R6", LW'(out_valid), LW'(1));
        e = expect_line(d, col);
        if (col % N == 0) check("R1", out_data, d);
        else if (col >= N) check("R3", out_data, e);
        else if (dir == 1) check("R4", out_data, e);
        else check("R2", out_data, e);
      end
    end

    // R7: hold while invalid
    d = make_line(99, 5, 0);
    push(5, 0, d);
    first = out_data;
    in_col = 6'd3; in_data = ~d;
    @(negedge clk);
    check("R7", out_data, first);
    check("R6", LW'(out_valid), LW'(0));

    // R5: round trip for every column ID
    for (int col = 0; col < (1 << CW); col++) begin
      d = make_line(col + 300, col, 2);
      push(col, 0, d);
      first = out_data;
      push(col, 1, first);
      check("R5", out_data, d);
    end

    // R9: strided gathers land in distinct chips
    for (int sidx = 0; sidx < 3; sidx++) begin
      automatic int stride = 2 << sidx;
      logic [N-1:0] hit = '0;
      for (int c = 0; c < N; c++) begin
        automatic int want = (stride * c) % N;
        d = make_line(500 + c, c, 3);
        push(c, 0, d);
        for (int j = 0; j < N; j++)
          if (out_data[j*W +: W] == d[want*W +: W]) hit[j] = 1'b1;
      end
      check("R9", LW'(hit), LW'(8'hFF));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule